// File: doc/BRIEF.md
# Offset-Selecting Set-Associative Branch Target Buffer

This block predicts branch targets for a front end that fetches aligned 16-byte blocks. One fetch block may hold several branches. Each branch sits in its own way of a 4-way set, and the way records the branch's byte position inside the block. A lookup is purely combinational. It compares the tag in every way of the indexed set. From the ways that match, it reports the one whose stored byte position is the smallest that is still at or after the current fetch position. Branches that lie behind the fetch point are skipped.

The execute stage trains the buffer with update requests. An update either refreshes an existing entry in place or allocates a new one into the victim way named by a 3-bit tree pseudo-LRU kept per set. When a predicted branch turns out not to be a branch at all, a flush request invalidates every way of that set at once. Lookups that hit and allocations both move the touched way to most-recently-used.

Top module: `btb_offset_sel`

## Requirements
- R1: After reset every way of every set is invalid and every tree is 000, so every lookup misses.
- R2: The byte offset is address bits [OFF_W-1:0], the set index is the next SET_W bits, and the tag is the TAG_W bits above the index. With the defaults these are [3:0], [12:4] and [21:13], giving 512 sets of 4 ways. Address bits above the tag are ignored.
- R3: `hit` is 1 only when `fetch_valid` is 1 and some valid way of the indexed set has an equal tag and a stored offset greater than or equal to the fetch offset. Otherwise `hit` is 0, and `hit_target` and `hit_offset` read 0.
- R4: When several ways qualify, the outputs carry the target and stored offset of the qualifying way with the smallest stored offset.
- R5: If an update names a set, tag and offset that a valid way already holds, only that way's target is rewritten. No other way changes.
- R6: Any other update writes the victim way. Tree bit 0 is the root and chooses ways 0-1 when 0 and ways 2-3 when 1. Bit 1 then picks way 1 over way 0 when set. Bit 2 picks way 3 over way 2 when set. From reset, four allocations to one set fill ways 0, 2, 1, 3 in that order.
- R7: Using way w, whether by a hit or by an update, sets the tree so that it points away from w. For w=0 or 1: root=1 and bit1=~w[0]. For w=2 or 3: root=0 and bit2=~w[0]. If an update and a hitting lookup touch the same set in one cycle, the update's touch is kept.
- R8: A flush clears all valid bits and the tree of its set at the next edge. An update to the same set in that cycle is discarded, and so is a lookup touch to that set.
- R9: A lookup sees the stored state from before the edge. An update or flush is visible to lookups from the cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A lookup is requested this cycle |
| fetch_addr | input | ADDR_W | Current fetch byte address |
| hit | output | 1 | A qualifying entry was found |
| hit_target | output | TGT_W | Predicted target of the selected entry |
| hit_offset | output | OFF_W | Stored byte offset of the selected entry |
| upd_valid | input | 1 | Training request from execute |
| upd_addr | input | ADDR_W | Byte address of the resolved branch |
| upd_target | input | TGT_W | Resolved target to store |
| flush_valid | input | 1 | Bogus-hit report: invalidate a set |
| flush_addr | input | ADDR_W | Address whose set is invalidated |

## Verification
A flush and an update can both fall in one cycle, and either may also coincide with a hitting lookup. The bench provokes this on purpose: it drives a flush and an update to the same set together, a flush to one set with an update to another, and an update into the set being looked up. After each case it sweeps every fetch offset of the affected sets. A cycle-level model computes which entries survive, what the tree now names as victim, and which target each offset must return. Long stretches of random traffic over two tags and four sets then make such collisions frequent, and every cycle's outputs are compared with that model.

// File: rtl/btb_offset_sel.sv
module btb_offset_sel #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int SET_W  = 9,
  parameter int TAG_W  = 9,
  parameter int TGT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              hit,
  output logic [TGT_W-1:0]  hit_target,
  output logic [OFF_W-1:0]  hit_offset,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [TGT_W-1:0]  upd_target,
  input  logic              flush_valid,
  input  logic [ADDR_W-1:0] flush_addr
);
  localparam int SETS   = 1 << SET_W;
  localparam int WAYS   = 4;
  localparam int TAG_LO = OFF_W + SET_W;

  function automatic logic [1:0] plru_victim(input logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin n[0] = 1'b1; n[1] = ~w[0]; end
    else       begin n[0] = 1'b0; n[2] = ~w[0]; end
    return n;
  endfunction

  logic [WAYS-1:0]  vld  [SETS];
  logic [2:0]       tree [SETS];
  logic [TAG_W-1:0] tg   [SETS][WAYS];
  logic [OFF_W-1:0] bo   [SETS][WAYS];
  logic [TGT_W-1:0] tt   [SETS][WAYS];

  wire [SET_W-1:0] fset = fetch_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] ftag = fetch_addr[TAG_LO +: TAG_W];
  wire [OFF_W-1:0] foff = fetch_addr[OFF_W-1:0];
  wire [SET_W-1:0] uset = upd_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] utag = upd_addr[TAG_LO +: TAG_W];
  wire [OFF_W-1:0] uoff = upd_addr[OFF_W-1:0];
  wire [SET_W-1:0] xset = flush_addr[OFF_W +: SET_W];

  logic             found;
  logic [1:0]       hway;
  logic [OFF_W-1:0] hoff;
  logic [TGT_W-1:0] htgt;

  always_comb begin
    found = 1'b0;
    hway  = '0;
    hoff  = '0;
    htgt  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[fset][w] && tg[fset][w] == ftag && bo[fset][w] >= foff &&
          (!found || bo[fset][w] < hoff)) begin
        found = 1'b1;
        hway  = 2'(w);
        hoff  = bo[fset][w];
        htgt  = tt[fset][w];
      end
    end
  end

  assign hit        = fetch_valid && found;
  assign hit_target = hit ? htgt : '0;
  assign hit_offset = hit ? hoff : '0;

  logic       refresh;
  logic [1:0] rway;

  always_comb begin
    refresh = 1'b0;
    rway    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[uset][w] && tg[uset][w] == utag && bo[uset][w] == uoff) begin
        refresh = 1'b1;
        rway    = 2'(w);
      end
    end
  end

  wire [1:0] uway   = refresh ? rway : plru_victim(tree[uset]);
  wire       upd_go = upd_valid && !(flush_valid && xset == uset);

  always_ff @(posedge clk) begin
    if (upd_go) begin
      tg[uset][uway] <= utag;
      bo[uset][uway] <= uoff;
      tt[uset][uway] <= upd_target;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    wire fl_here  = flush_valid && xset == SET_W'(s);
    wire upd_here = upd_go && uset == SET_W'(s);
    wire hit_here = hit && fset == SET_W'(s);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[s]  <= '0;
        tree[s] <= '0;
      end else if (fl_here) begin
        vld[s]  <= '0;
        tree[s] <= '0;
      end else if (upd_here) begin
        vld[s][uway] <= 1'b1;
        tree[s]      <= plru_touch(tree[s], uway);
      end else if (hit_here) begin
        tree[s] <= plru_touch(tree[s], hway);
      end
    end
  end
endmodule

module btb_offset_sel_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int SET_W  = 9,
  parameter int TAG_W  = 9,
  parameter int TGT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              hit,
  input logic [TGT_W-1:0]  hit_target,
  input logic [OFF_W-1:0]  hit_offset,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_addr,
  input logic [TGT_W-1:0]  upd_target,
  input logic              flush_valid,
  input logic [ADDR_W-1:0] flush_addr
);
  localparam int KEY_W = OFF_W + SET_W + TAG_W;

  wire [SET_W-1:0] f_set = fetch_addr[OFF_W +: SET_W];
  wire [SET_W-1:0] u_set = upd_addr[OFF_W +: SET_W];
  wire [SET_W-1:0] x_set = flush_addr[OFF_W +: SET_W];

  a_r3_no_fetch_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !hit);

  a_r4_offset_not_behind: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_offset >= fetch_addr[OFF_W-1:0]);

  a_r8_flushed_set_misses: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> !(hit && f_set == $past(x_set)));

  a_r9_update_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !(flush_valid && x_set == u_set)) |=>
      ((fetch_valid && fetch_addr[KEY_W-1:0] == $past(upd_addr[KEY_W-1:0])) |->
        (hit && hit_target == $past(upd_target) &&
         hit_offset == $past(upd_addr[OFF_W-1:0]))));
endmodule

bind btb_offset_sel btb_offset_sel_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .TAG_W(TAG_W), .TGT_W(TGT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .hit(hit), .hit_target(hit_target), .hit_offset(hit_offset),
  .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_target(upd_target),
  .flush_valid(flush_valid), .flush_addr(flush_addr)
);

// File: tb/btb_offset_sel_test.sv
module btb_offset_sel_test;
  localparam int AW = 12;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0, upd_valid = 1'b0, flush_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0, upd_addr = '0, flush_addr = '0;
  logic [TW-1:0] upd_target = '0;
  logic          hit;
  logic [TW-1:0] hit_target;
  logic [3:0]    hit_offset;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  btb_offset_sel #(.ADDR_W(AW), .OFF_W(4), .SET_W(2), .TAG_W(3), .TGT_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .hit(hit), .hit_target(hit_target), .hit_offset(hit_offset),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_target(upd_target),
    .flush_valid(flush_valid), .flush_addr(flush_addr));

  logic          mv   [4][4];
  logic [2:0]    mtag [4][4];
  logic [3:0]    moff [4][4];
  logic [TW-1:0] mtgt [4][4];
  logic [2:0]    mtr  [4];

  function automatic logic [AW-1:0] mk(input int tag, input int set, input int off);
    return {3'b000, 3'(tag), 2'(set), 4'(off)};
  endfunction

  function automatic logic [1:0] victim(input logic [2:0] t);
    if (t[0] == 1'b0) return t[1] ? 2'd1 : 2'd0;
    return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    if (w < 2) begin n[0] = 1'b1; n[1] = (w == 0); end
    else       begin n[0] = 1'b0; n[2] = (w == 2); end
    return n;
  endfunction

  task automatic cyc(input string rq, input logic fv, input logic [AW-1:0] fa,
                     input logic uv, input logic [AW-1:0] ua, input logic [TW-1:0] ut,
                     input logic xv, input logic [AW-1:0] xa);
    logic eh; logic [TW-1:0] et; logic [3:0] eo; logic [1:0] ew;
    int ls, us, xs, fo; logic rf; logic [1:0] uw; logic ugo;
    @(negedge clk);
    fetch_valid = fv; fetch_addr = fa; upd_valid = uv; upd_addr = ua;
    upd_target = ut; flush_valid = xv; flush_addr = xa;
    #1;
    ls = int'(fa[5:4]); fo = int'(fa[3:0]);
    eh = 1'b0; et = '0; eo = '0; ew = '0;
    for (int w = 0; w < 4; w++)
      if (fv && mv[ls][w] && mtag[ls][w] == fa[8:6] && int'(moff[ls][w]) >= fo &&
          (!eh || moff[ls][w] < eo)) begin
        eh = 1'b1; et = mtgt[ls][w]; eo = moff[ls][w]; ew = 2'(w);
      end
    checks++;
    if (hit !== eh || hit_target !== et || hit_offset !== eo) begin
      errors++;
      $display("FAIL %s addr=%h hit=%0b tgt=%h off=%0d expected hit=%0b tgt=%h off=%0d",
               rq, fa, hit, hit_target, hit_offset, eh, et, eo);
    end
    us = int'(ua[5:4]); xs = int'(xa[5:4]);
    rf = 1'b0; uw = victim(mtr[us]);
    for (int w = 0; w < 4; w++)
      if (mv[us][w] && mtag[us][w] == ua[8:6] && moff[us][w] == ua[3:0]) begin
        rf = 1'b1; uw = 2'(w);
      end
    ugo = uv && !(xv && xs == us);
    if (xv) begin
      for (int w = 0; w < 4; w++) mv[xs][w] = 1'b0;
      mtr[xs] = '0;
    end
    if (ugo) begin
      mv[us][uw] = 1'b1; mtag[us][uw] = ua[8:6]; moff[us][uw] = ua[3:0];
      mtgt[us][uw] = ut; mtr[us] = touch(mtr[us], uw);
    end
    if (eh && !(xv && xs == ls) && !(ugo && us == ls)) mtr[ls] = touch(mtr[ls], ew);
  endtask

  task automatic look(input string rq, input int tag, input int set, input int off);
    cyc(rq, 1'b1, mk(tag, set, off), 1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic upd(input string rq, input int tag, input int set, input int off,
                     input int tgt);
    cyc(rq, 1'b0, '0, 1'b1, mk(tag, set, off), TW'(tgt), 1'b0, '0);
  endtask

  task automatic sweep(input string rq, input int tag, input int set);
    for (int o = 0; o < 16; o++) look(rq, tag, set, o);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      mtr[s] = '0;
      for (int w = 0; w < 4; w++) begin
        mv[s][w] = 1'b0; mtag[s][w] = '0; moff[s][w] = '0; mtgt[s][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) sweep("R1 reset miss", s, s);

    upd("R6 fill", 5, 1, 10, 'h10A);
    upd("R6 fill", 5, 1, 2,  'h102);
    upd("R6 fill", 5, 1, 14, 'h10E);
    upd("R6 fill", 5, 1, 6,  'h106);
    sweep("R4 lowest offset not behind fetch", 5, 1);
    sweep("R3 tag mismatch", 4, 1);
    sweep("R2 other set", 5, 0);
    cyc("R3 fetch_valid low", 1'b0, mk(5, 1, 0), 1'b0, '0, '0, 1'b0, '0);
    cyc("R2 upper bits ignored", 1'b1, mk(5, 1, 3) | 12'hE00, 1'b0, '0, '0, 1'b0, '0);

    cyc("R9 lookup sees old state", 1'b1, mk(2, 2, 4), 1'b1, mk(2, 2, 4), 'h224, 1'b0, '0);
    look("R9 update visible next cycle", 2, 2, 4);

    upd("R5 refresh in place", 5, 1, 6, 'h1F6);
    sweep("R5 refresh result", 5, 1);

    upd("R7 allocate after touches", 5, 1, 0, 'h100);
    sweep("R6 victim replaced", 5, 1);
    look("R7 hit touch", 5, 1, 15);
    upd("R7 allocate after hit", 5, 1, 1, 'h101);
    sweep("R7 victim after hit touch", 5, 1);

    cyc("R7 update and hit same set", 1'b1, mk(5, 1, 0), 1'b1, mk(6, 1, 3), 'h163,
        1'b0, '0);
    upd("R7 next victim", 6, 1, 4, 'h164);
    sweep("R7 tag 5 after collision", 5, 1);
    sweep("R7 tag 6 after collision", 6, 1);

    cyc("R8 flush beats update", 1'b1, mk(5, 1, 0), 1'b1, mk(5, 1, 9), 'h199,
        1'b1, mk(0, 1, 0));
    sweep("R8 flushed set", 5, 1);
    sweep("R8 flushed set other tag", 6, 1);
    cyc("R8 flush other set", 1'b0, '0, 1'b1, mk(3, 3, 7), 'h337, 1'b1, mk(0, 2, 0));
    look("R8 set 2 gone", 2, 2, 4);
    look("R8 set 3 kept update", 3, 3, 7);
    upd("R8 tree cleared", 7, 2, 5, 'h275);
    upd("R8 tree cleared", 7, 2, 6, 'h276);
    sweep("R8 refill after flush", 7, 2);

    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] fa, ua, xa;
      logic fv, uv, xv;
      fa = {$urandom_range(0, 7) == 0 ? 3'b101 : 3'b000, 2'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
      ua = mk($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 15));
      xa = mk(0, $urandom_range(0, 3), 0);
      fv = $urandom_range(0, 3) != 0;
      uv = $urandom_range(0, 2) == 0;
      xv = $urandom_range(0, 24) == 0;
      cyc("R4 random traffic", fv, fa, uv, ua, TW'($urandom), xv, xa);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule